// File: doc/BRIEF.md
# CPU Breakpoint Comparator

This block watches the CPU bus and raises either a software-interrupt request or a request to enter background debug. It has two address comparators. A small register file, written through a plain write port, sets each comparator's reference address and the qualifier bits. A two-bit mode field picks one of four behaviours: off, two address comparators that raise software interrupts, a single comparator that enters debug and can also match on address, direction and masked data, or two address comparators that enter debug.

In program-fetch operation a match only tags the fetch. The request is raised in the cycle after the tagged instruction is reported as executing (`exec_valid`). A pipeline flush throws the tag away. In data operation the request follows the matching non-fetch bus cycle by one clock. While the CPU runs its debug code (`dbg_active`) no request of either kind is issued. A debug request also needs `dbg_enabled`. Both outputs are registered and stay high for one clock per hit.

Top module: `bkpt_unit`

## Requirements
- R1: While reset is asserted and after reset, `swi_req` and `dbg_req` are low and every configuration register reads as zero, so the unit is off.
- R2: Configuration selects: 0 = control, 1 = direction bits, 2/3 = comparator 0 reference address high/low byte, 4/5 = comparator 1 reference high/low byte (in full mode these hold the data pattern). Selects 6 and 7 are ignored. Control bits: [1:0] mode (0 off, 1 dual-SWI, 2 full, 3 dual-debug), [2] fetch select, [3] data enable, [4] comparator 0 low-byte enable, [5] comparator 1 low-byte enable, [6] high-byte mask, [7] low-byte mask. Direction bits: [0] comparator 0 direction (1 = read), [1] comparator 0 direction check, [2] comparator 1 direction, [3] comparator 1 direction check.
- R3: In dual-SWI mode a fetch whose address matches an enabled comparator tags the instruction, and `swi_req` pulses one clock after it executes. The high byte is always compared, and the low byte only when that comparator's low-byte enable is set. Comparator 0 is always on, and comparator 1 is on only when the data enable bit is set.
- R4: In dual-SWI mode the fetch select, direction bits and mask bits have no effect, and non-fetch bus cycles never produce a request.
- R5: In full mode with fetch select clear, a non-fetch bus cycle matching comparator 0's address, its direction check and (when data enable is set) the data pattern causes `dbg_req` one clock later. A set mask bit drops that data byte from the compare.
- R6: In full mode comparator 1's address, low-byte enable and direction bits have no effect.
- R7: When fetch select is set in full or dual-debug mode, matching is on fetches with execution tagging, and the data, mask and direction bits have no effect.
- R8: In dual-debug mode with fetch select clear, each comparator matches non-fetch cycles using its own low-byte enable and direction check. Comparator 1 is on only when data enable is set, and the mask bits have no effect.
- R9: `dbg_req` is never raised while `dbg_enabled` is low. Software-interrupt requests do not depend on it.
- R10: No request is raised in the clock after a cycle with `dbg_active` high, including for an instruction that was tagged earlier.
- R11: A tag waits through idle cycles until the next executing instruction, is consumed by it, and is discarded by `exec_flush`. Each hit gives exactly one clock of request.
- R12: In mode 0 no request is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | AW/2 | Configuration write data |
| bus_valid | input | 1 | Bus cycle in progress |
| bus_fetch | input | 1 | Bus cycle is an instruction fetch |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | AW | Bus address |
| bus_data | input | AW | Bus data |
| exec_valid | input | 1 | Next fetched instruction starts executing |
| exec_flush | input | 1 | Pipeline flush, discards fetched instructions |
| dbg_enabled | input | 1 | Background debug is enabled |
| dbg_active | input | 1 | CPU is running debug code |
| swi_req | output | 1 | Software-interrupt request pulse |
| dbg_req | output | 1 | Debug-entry request pulse |

## Verification
The bench goes after the control bits whose meaning changes with the mode. A design that let direction or mask bits leak into dual-SWI mode would lose the fetch hit. One that compared comparator 1's address in full mode would fire on the data-pattern address. The tagged fetch is exercised across idle cycles, a flush and back-to-back executes: a wrong design pulses at fetch time, never clears the tag, or pulses twice. `dbg_active` and `dbg_enabled` are flipped around pending tags and live data hits, and a design that missed a gate shows a stray request.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SWI2 = 2'd1,
    MODE_FULL = 2'd2,
    MODE_DBG2 = 2'd3
  } bk_mode_e;

  typedef struct packed {
    logic     mask_lo;
    logic     mask_hi;
    logic     lo_en1;
    logic     lo_en0;
    logic     data_en;
    logic     pf_sel;
    bk_mode_e mode;
  } bk_ctrl_t;

  // fetch tagging is forced in dual-SWI mode
  function automatic logic fetch_based(bk_ctrl_t c);
    return (c.mode == MODE_SWI2) || c.pf_sel;
  endfunction

  function automatic logic second_on(bk_ctrl_t c);
    return ((c.mode == MODE_SWI2) || (c.mode == MODE_DBG2)) && c.data_en;
  endfunction

  function automatic logic debug_kind(bk_ctrl_t c);
    return c.mode != MODE_SWI2;
  endfunction

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs #(
  parameter int CW   = 8,
  parameter int NREG = 6,
  parameter int SW   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [SW-1:0]             sel,
  input  logic [CW-1:0]             wdata,
  output logic [NREG-1:0][CW-1:0]   regs_o
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         regs_o[i] <= '0;
      else if (we && sel == SW'(i))       regs_o[i] <= wdata;
    end
  end

  // R2
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel >= SW'(NREG)) |=> $stable(regs_o));

endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] bus_addr,
  input  logic [AW-1:0] bus_data,
  input  logic          bus_rd,
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] ref_data,
  input  logic          lo_en,
  input  logic          rw_val,
  input  logic          rw_chk,
  input  logic          data_chk,
  input  logic          mask_hi,
  input  logic          mask_lo,
  output logic          hit
);
  localparam int H = AW / 2;

  function automatic logic half_ok(logic [H-1:0] a, logic [H-1:0] b, logic skip);
    return skip || (a == b);
  endfunction

  logic addr_ok, rw_ok, data_ok;

  assign addr_ok = half_ok(bus_addr[AW-1:H], ref_addr[AW-1:H], 1'b0) &&
                   half_ok(bus_addr[H-1:0], ref_addr[H-1:0], !lo_en);
  assign rw_ok   = !rw_chk || (bus_rd == rw_val);
  assign data_ok = !data_chk ||
                   (half_ok(bus_data[AW-1:H], ref_data[AW-1:H], mask_hi) &&
                    half_ok(bus_data[H-1:0], ref_data[H-1:0], mask_lo));
  assign hit     = addr_ok && rw_ok && data_ok;

endmodule

// File: rtl/bkpt_tag.sv
module bkpt_tag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic set_dbg,
  input  logic exec_valid,
  input  logic flush,
  input  logic clear,
  output logic fire_swi,
  output logic fire_dbg,
  output logic pending
);
  logic kind_q;
  logic fire;

  assign fire     = exec_valid && pending && !flush;
  assign fire_swi = fire && !kind_q;
  assign fire_dbg = fire && kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      kind_q  <= 1'b0;
    end else if (set) begin
      pending <= 1'b1;
      kind_q  <= set_dbg;
    end else if (exec_valid || flush || clear) begin
      pending <= 1'b0;
    end
  end

  // R11
  flush_drops_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !set) |=> !pending);

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int AW = 16,
  localparam int CW = AW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          bus_valid,
  input  logic          bus_fetch,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [AW-1:0] bus_data,
  input  logic          exec_valid,
  input  logic          exec_flush,
  input  logic          dbg_enabled,
  input  logic          dbg_active,
  output logic          swi_req,
  output logic          dbg_req
);
  localparam int NREG = 6;
  localparam int NCMP = 2;

  logic [NREG-1:0][CW-1:0] cfg_q;
  bk_ctrl_t                ctrl;
  logic                    pf_eff;
  logic [NCMP-1:0][AW-1:0] ref_addr;
  logic [NCMP-1:0]         cmp_on, rw_val, rw_chk, data_chk, lo_en, cmp_hit;
  logic                    any_hit, fetch_hit, data_hit;
  logic                    fire_swi, fire_dbg, tag_pending;
  logic                    unused_cfg;

  bkpt_regs #(.CW(CW), .NREG(NREG), .SW(3)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .regs_o(cfg_q));

  assign ctrl       = bk_ctrl_t'(cfg_q[0][7:0]);
  assign unused_cfg = ^{cfg_q[1][CW-1:4], cfg_q[0][CW-1:8]};
  assign pf_eff     = fetch_based(ctrl);

  assign ref_addr[0] = {cfg_q[2], cfg_q[3]};
  assign ref_addr[1] = {cfg_q[4], cfg_q[5]};

  assign cmp_on[0]   = ctrl.mode != MODE_OFF;
  assign cmp_on[1]   = second_on(ctrl);
  assign lo_en[0]    = ctrl.lo_en0;
  assign lo_en[1]    = ctrl.lo_en1;
  assign rw_val[0]   = cfg_q[1][0];
  assign rw_val[1]   = cfg_q[1][2];
  assign rw_chk[0]   = cfg_q[1][1] && !pf_eff;
  assign rw_chk[1]   = cfg_q[1][3] && !pf_eff && (ctrl.mode == MODE_DBG2);
  assign data_chk[0] = ctrl.data_en && !pf_eff && (ctrl.mode == MODE_FULL);
  assign data_chk[1] = 1'b0;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    logic raw_hit;
    bkpt_cmp #(.AW(AW)) u_cmp (
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_rd(bus_rd),
      .ref_addr(ref_addr[g]), .ref_data(ref_addr[1]),
      .lo_en(lo_en[g]), .rw_val(rw_val[g]), .rw_chk(rw_chk[g]),
      .data_chk(data_chk[g]), .mask_hi(ctrl.mask_hi), .mask_lo(ctrl.mask_lo),
      .hit(raw_hit));
    assign cmp_hit[g] = raw_hit && cmp_on[g];
  end

  assign any_hit   = |cmp_hit;
  assign fetch_hit = pf_eff && bus_valid && bus_fetch && any_hit && !dbg_active;
  assign data_hit  = !pf_eff && bus_valid && !bus_fetch && any_hit;

  bkpt_tag u_tag (
    .clk(clk), .rst_n(rst_n), .set(fetch_hit), .set_dbg(debug_kind(ctrl)),
    .exec_valid(exec_valid), .flush(exec_flush),
    .clear(ctrl.mode == MODE_OFF),
    .fire_swi(fire_swi), .fire_dbg(fire_dbg), .pending(tag_pending));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swi_req <= 1'b0;
      dbg_req <= 1'b0;
    end else begin
      swi_req <= fire_swi && !dbg_active;
      dbg_req <= (fire_dbg || data_hit) && dbg_enabled && !dbg_active;
    end
  end

  // R10
  active_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_active |=> (!swi_req && !dbg_req));

  // R9
  dbg_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_enabled |=> !dbg_req);

  // R12
  off_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode == MODE_OFF && !tag_pending) |=> (!swi_req && !dbg_req));

  // R3
  swi_after_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swi_req |-> $past(exec_valid));

  // R4
  swi_mode_no_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode == MODE_SWI2 && !tag_pending) |=> !dbg_req);

endmodule

// File: tb/tb_bkpt_unit.sv
module tb_bkpt_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        bus_valid = 1'b0, bus_fetch = 1'b0, bus_rd = 1'b1;
  logic [15:0] bus_addr = '0, bus_data = '0;
  logic        exec_valid = 1'b0, exec_flush = 1'b0;
  logic        dbg_enabled = 1'b1, dbg_active = 1'b0;
  logic        swi_req, dbg_req;

  bkpt_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_fetch(bus_fetch),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_data(bus_data),
    .exec_valid(exec_valid), .exec_flush(exec_flush),
    .dbg_enabled(dbg_enabled), .dbg_active(dbg_active),
    .swi_req(swi_req), .dbg_req(dbg_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0, failures = 0;
  string cur_req = "R1";
  int    cnt_swi = 0, cnt_dbg = 0, snap_swi = 0, snap_dbg = 0;

  // reference model state
  int cfg[6];
  int tag = 0, tag_dbg = 0;
  bit exp_swi = 0, exp_dbg = 0;
  int m_mode, m_pf, m_den, m_l0, m_l1, m_mh, m_ml, m_rw, m_hi, m_lo, m_dhi, m_dlo;
  bit m_fetch_based, h0, h1, m_fh, m_dh, m_fire;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (cfg[i]) cfg[i] = 0;
      tag = 0; tag_dbg = 0; exp_swi = 0; exp_dbg = 0;
    end else begin
      m_mode = cfg[0] % 4;        m_pf  = (cfg[0] / 4) % 2;
      m_den  = (cfg[0] / 8) % 2;  m_l0  = (cfg[0] / 16) % 2;
      m_l1   = (cfg[0] / 32) % 2; m_mh  = (cfg[0] / 64) % 2;
      m_ml   = (cfg[0] / 128) % 2; m_rw = cfg[1];
      m_hi = int'(bus_addr) / 256;  m_lo = int'(bus_addr) % 256;
      m_dhi = int'(bus_data) / 256; m_dlo = int'(bus_data) % 256;
      m_fetch_based = (m_mode == 1) || (m_pf == 1);
      h0 = (m_mode != 0) && (m_hi == cfg[2]) && (m_l0 == 0 || m_lo == cfg[3]);
      h1 = (m_mode == 1 || m_mode == 3) && (m_den == 1) &&
           (m_hi == cfg[4]) && (m_l1 == 0 || m_lo == cfg[5]);
      if (!m_fetch_based) begin
        if ((m_rw / 2) % 2 == 1 && int'(bus_rd) != m_rw % 2) h0 = 0;
        if (m_mode == 2 && m_den == 1) begin
          if (m_mh == 0 && m_dhi != cfg[4]) h0 = 0;
          if (m_ml == 0 && m_dlo != cfg[5]) h0 = 0;
        end
        if (m_mode == 3 && (m_rw / 8) % 2 == 1 && int'(bus_rd) != (m_rw / 4) % 2) h1 = 0;
      end
      m_fh = m_fetch_based && bus_valid && bus_fetch && (h0 || h1) && !dbg_active;
      m_dh = !m_fetch_based && bus_valid && !bus_fetch && (h0 || h1);
      m_fire = exec_valid && (tag == 1) && !exec_flush;
      exp_swi = m_fire && (tag_dbg == 0) && !dbg_active;
      exp_dbg = ((m_fire && tag_dbg == 1) || m_dh) && dbg_enabled && !dbg_active;
      if (m_fh) begin tag = 1; tag_dbg = (m_mode != 1); end
      else if (exec_valid || exec_flush || m_mode == 0) tag = 0;
      if (cfg_we && cfg_sel < 6) cfg[cfg_sel] = int'(cfg_wdata);
    end
  end

  always @(negedge clk) begin
    checks++;
    if (swi_req !== exp_swi || dbg_req !== exp_dbg) begin
      failures++;
      $display("FAIL %s: swi=%b dbg=%b expected swi=%b dbg=%b at %0t",
               cur_req, swi_req, dbg_req, exp_swi, exp_dbg, $time);
    end
    if (swi_req === 1'b1) cnt_swi++;
    if (dbg_req === 1'b1) cnt_dbg++;
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wcfg(int sel, int d);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int ctl(int mode, int pf, int den, int l0, int l1, int mh, int ml);
    return mode + pf*4 + den*8 + l0*16 + l1*32 + mh*64 + ml*128;
  endfunction

  task automatic bus(int a, int d, bit rd, bit f);
    bus_valid = 1'b1; bus_addr = 16'(a); bus_data = 16'(d); bus_rd = rd; bus_fetch = f;
    @(negedge clk);
    bus_valid = 1'b0; bus_fetch = 1'b0;
  endtask

  task automatic execute();
    exec_valid = 1'b1;
    @(negedge clk);
    exec_valid = 1'b0;
  endtask

  task automatic flush();
    exec_flush = 1'b1;
    @(negedge clk);
    exec_flush = 1'b0;
  endtask

  task automatic expect_pulses(string r, int es, int ed);
    idle(2);
    checks++;
    if (cnt_swi - snap_swi != es || cnt_dbg - snap_dbg != ed) begin
      failures++;
      $display("FAIL %s: pulses swi=%0d dbg=%0d expected swi=%0d dbg=%0d",
               r, cnt_swi - snap_swi, cnt_dbg - snap_dbg, es, ed);
    end
    snap_swi = cnt_swi; snap_dbg = cnt_dbg;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    idle(3);
    rst_n = 1'b1;
    idle(2);
    checks++;
    if (swi_req !== 1'b0 || dbg_req !== 1'b0) begin
      failures++;
      $display("FAIL R1: swi=%b dbg=%b expected 0 0", swi_req, dbg_req);
    end
    bus(16'h1234, 0, 1, 1); execute();
    expect_pulses("R1", 0, 0);

    // R2: reference registers, unmapped selects ignored
    cur_req = "R2";
    wcfg(2, 8'h12); wcfg(3, 8'h34); wcfg(4, 8'h56); wcfg(5, 8'hAB);
    wcfg(6, 8'hFF); wcfg(7, 8'hFF);
    expect_pulses("R2", 0, 0);

    // R12: mode 0
    cur_req = "R12";
    wcfg(0, ctl(0, 1, 1, 1, 1, 0, 0));
    bus(16'h1234, 0, 1, 1); execute(); bus(16'h1234, 0, 1, 0);
    expect_pulses("R12", 0, 0);

    // R3: dual-SWI mode
    cur_req = "R3";
    wcfg(0, ctl(1, 0, 0, 1, 1, 0, 0));
    bus(16'h1234, 0, 1, 1); execute();
    expect_pulses("R3 comparator 0", 1, 0);
    bus(16'h56AB, 0, 1, 1); execute();
    expect_pulses("R3 comparator 1 off", 0, 0);
    wcfg(0, ctl(1, 0, 1, 1, 1, 0, 0));
    bus(16'h56AB, 0, 1, 1); execute();
    expect_pulses("R3 comparator 1 on", 1, 0);
    wcfg(0, ctl(1, 0, 1, 1, 0, 0, 0));
    bus(16'h56FF, 0, 1, 1); execute();
    expect_pulses("R3 high byte only", 1, 0);
    bus(16'h1235, 0, 1, 1); execute();
    expect_pulses("R3 low byte compared", 0, 0);

    // R4: ignored bits in dual-SWI mode
    cur_req = "R4";
    wcfg(0, ctl(1, 1, 1, 1, 1, 1, 1)); wcfg(1, 8'h0A);
    bus(16'h1234, 0, 1, 1); execute();
    expect_pulses("R4 fetch", 1, 0);
    bus(16'h1234, 0, 1, 0); bus(16'h1234, 0, 0, 0);
    expect_pulses("R4 data cycles", 0, 0);

    // R5: full mode data breakpoint
    cur_req = "R5";
    wcfg(4, 8'hBE); wcfg(5, 8'hEF); wcfg(1, 8'h03);
    wcfg(0, ctl(2, 0, 1, 1, 0, 0, 0));
    bus(16'h1234, 16'hBEEF, 1, 0);
    expect_pulses("R5 full match", 0, 1);
    bus(16'h1234, 16'hBEEE, 1, 0);
    bus(16'h1234, 16'hBEEF, 0, 0);
    bus(16'h1235, 16'hBEEF, 1, 0);
    bus(16'h1234, 0, 1, 1); execute();
    expect_pulses("R5 mismatches", 0, 0);
    wcfg(0, ctl(2, 0, 1, 1, 0, 0, 1));
    bus(16'h1234, 16'hBEEE, 1, 0);
    expect_pulses("R5 low mask", 0, 1);
    wcfg(0, ctl(2, 0, 0, 1, 0, 0, 0));
    bus(16'h1234, 16'h0000, 1, 0);
    expect_pulses("R5 data off", 0, 1);

    // R6: comparator 1 bits ignored in full mode
    cur_req = "R6";
    wcfg(0, ctl(2, 0, 1, 1, 1, 0, 0)); wcfg(1, 8'h0F);
    bus(16'h1234, 16'hBEEF, 1, 0);
    expect_pulses("R6 still matches", 0, 1);
    bus(16'h1234, 16'hBEEF, 0, 0);
    bus(16'hBEEF, 16'hBEEF, 1, 0);
    expect_pulses("R6 no second comparator", 0, 0);

    // R7: fetch select
    cur_req = "R7";
    wcfg(0, ctl(2, 1, 1, 1, 0, 0, 0)); wcfg(1, 8'h02);
    bus(16'h1234, 0, 1, 1);
    idle(1);
    execute();
    expect_pulses("R7 full fetch", 0, 1);
    bus(16'h1234, 16'hBEEF, 1, 0);
    expect_pulses("R7 data ignored", 0, 0);
    wcfg(4, 8'h56); wcfg(5, 8'hAB);
    wcfg(0, ctl(3, 1, 1, 1, 1, 0, 0));
    bus(16'h56AB, 0, 1, 1); execute();
    expect_pulses("R7 dual fetch", 0, 1);

    // R8: dual-debug data
    cur_req = "R8";
    wcfg(0, ctl(3, 0, 1, 1, 1, 1, 1)); wcfg(1, 8'h0B);
    bus(16'h1234, 16'h0000, 1, 0);
    expect_pulses("R8 c0 read", 0, 1);
    bus(16'h1234, 0, 0, 0);
    expect_pulses("R8 c0 write", 0, 0);
    bus(16'h56AB, 0, 0, 0);
    expect_pulses("R8 c1 write", 0, 1);
    bus(16'h56AB, 0, 1, 0);
    expect_pulses("R8 c1 read", 0, 0);
    wcfg(0, ctl(3, 0, 0, 1, 1, 0, 0));
    bus(16'h56AB, 0, 0, 0);
    expect_pulses("R8 c1 off", 0, 0);

    // R9: debug enable
    cur_req = "R9";
    dbg_enabled = 1'b0;
    bus(16'h1234, 0, 1, 0);
    expect_pulses("R9 blocked", 0, 0);
    wcfg(0, ctl(1, 0, 0, 1, 1, 0, 0));
    bus(16'h1234, 0, 1, 1); execute();
    expect_pulses("R9 swi unaffected", 1, 0);
    dbg_enabled = 1'b1;

    // R10: debug active
    cur_req = "R10";
    dbg_active = 1'b1;
    bus(16'h1234, 0, 1, 1); execute();
    wcfg(0, ctl(3, 0, 0, 1, 1, 0, 0));
    bus(16'h1234, 0, 1, 0);
    dbg_active = 1'b0;
    expect_pulses("R10 active", 0, 0);
    wcfg(0, ctl(1, 0, 0, 1, 1, 0, 0));
    bus(16'h1234, 0, 1, 1);
    dbg_active = 1'b1; execute(); dbg_active = 1'b0;
    expect_pulses("R10 tag then active", 0, 0);

    // R11: tag lifetime
    cur_req = "R11";
    bus(16'h1234, 0, 1, 1); flush(); execute();
    expect_pulses("R11 flush", 0, 0);
    bus(16'h1234, 0, 1, 1); idle(3); execute(); execute();
    expect_pulses("R11 single pulse", 1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule